// File: doc/BRIEF.md
# Ratioed Clock-Domain Transfer Aligner

This block runs in a fast clock domain that exchanges data with a slower domain. Both clocks are derived from one reference, so the fast-to-slow frequency ratio is exact. The ratio is a multiple of one quarter between 2.0 and 5.25. Because the ratio may be fractional, a slow rising edge falls on a fast rising edge only at certain fast cycles. The block keeps a phase accumulator in quarter units and marks each fast cycle that ends on a shared edge.

The ratio is given as a count of quarters, so 2.5 is written 10. A synchronous restart pulse, tied to the reference edge, loads the ratio and starts tracking. The `aligned` output leads each shared edge by one fast cycle. This gives the launched data that one cycle to reach the slow side. In every aligned cycle, one word is launched in each direction at the same time. The fast-side word is held toward the slow side until the next aligned cycle. The slow-side word is handed to the fast side with a valid flag that lasts one cycle.

Top module: `ratio_aligner`

## Requirements
- R1: `ratioCode` gives the fast:slow ratio in quarter units, so a code of Q means Q/4 fast cycles per slow cycle. It is sampled only on a clock edge where `restart` is high.
- R2: Number the fast cycles from 0, where cycle 0 is the first cycle after the restart edge. `aligned` is high in cycle k exactly when 4·(k+1) mod Q equals 0. That is one cycle before each fast edge that lines up with a slow edge.
- R3: A code below 8 acts as 8, and a code above 21 acts as 21.
- R4: A change of `ratioCode` with `restart` low has no effect on the `aligned` pattern.
- R5: While reset is applied, all outputs are 0. After reset, `aligned` stays low until the first restart.
- R6: At the end of an aligned cycle, `toSlowData` and `toSlowValid` take `f2sData` and `f2sValid`. At all other times they hold their value, except that a restart clears `toSlowValid`.
- R7: At the end of an aligned cycle, `toFastData` takes `s2fData`. `toFastValid` is high for exactly the one following cycle, and only if `s2fValid` was high.
- R8: A restart in the middle of a run re-phases the pattern from cycle 0 and clears both valid outputs. This takes priority over a launch on the same edge.
- R9: `aligned` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast-domain clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ratioCode | input | RATIO_W | Ratio in quarter units (8..21) |
| restart | input | 1 | Synchronous restart on the reference edge |
| f2sData | input | DATA_W | Word from the fast side toward the slow side |
| f2sValid | input | 1 | `f2sData` carries new data |
| s2fData | input | DATA_W | Word from the slow side toward the fast side |
| s2fValid | input | 1 | `s2fData` carries new data |
| aligned | output | 1 | High in the fast cycle before a shared edge |
| toSlowData | output | DATA_W | Held word presented to the slow domain |
| toSlowValid | output | 1 | Held word is new |
| toFastData | output | DATA_W | Word captured from the slow side |
| toFastValid | output | 1 | One-cycle valid for `toFastData` |

## Verification
A wrong accumulator value or wrong ratio register shows up on `aligned` within one pattern period. That period is at most 21 fast cycles. The pulse then appears in a wrong cycle, or it keeps the spacing of the previous ratio after a change that should have been ignored. A wrong launch strobe or wrong hold logic shows up on the cycle right after the aligned cycle. The word for one of the two sides is then missing, stale, or taken in a cycle that is not aligned. The bench compares every cycle against a quarter-unit model, so any such error is reported at the first cycle it occurs.

// File: rtl/ra_pkg.sv
package ra_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic launch;   // aligned cycle, transfer both ways at its end
    logic restart;  // re-phase; drop held valid flags
  } raStrobe_t;
endpackage

// File: rtl/ra_ctrl.sv
module ra_ctrl
  import ra_pkg::*;
#(
  parameter int RATIO_W = 5,
  parameter int MIN_Q   = 8,
  parameter int MAX_Q   = 21,
  parameter int STEP    = 4,
  parameter int LEAD    = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioCode,
  input  logic               restart,
  output raStrobe_t          strb,
  output logic               aligned
);
  localparam int SUM_W = RATIO_W + 1;

  logic [RATIO_W-1:0] ratioReg;
  logic [RATIO_W-1:0] accReg;
  logic [RATIO_W-1:0] accNext;
  logic [RATIO_W-1:0] accSeed;
  logic [RATIO_W-1:0] clampQ;
  logic [SUM_W-1:0]   sum;
  logic               running;

  // Out-of-range codes pinned to the legal span
  always_comb begin
    if (ratioCode < RATIO_W'(MIN_Q))      clampQ = RATIO_W'(MIN_Q);
    else if (ratioCode > RATIO_W'(MAX_Q)) clampQ = RATIO_W'(MAX_Q);
    else                                  clampQ = ratioCode;
  end

  // Phase of cycle 0 is the lead distance, in quarters, modulo the ratio
  always_comb accSeed = RATIO_W'((STEP * LEAD) % int'(clampQ));

  // Advance by one fast cycle (STEP quarters), wrap once at the ratio
  always_comb begin
    sum = {1'b0, accReg} + SUM_W'(STEP);
    if (sum >= {1'b0, ratioReg}) accNext = RATIO_W'(sum - {1'b0, ratioReg});
    else                         accNext = RATIO_W'(sum);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratioReg <= RATIO_W'(MIN_Q);
      accReg   <= '0;
      running  <= 1'b0;
    end else if (restart) begin
      ratioReg <= clampQ;
      accReg   <= accSeed;
      running  <= 1'b1;
    end else if (running) begin
      accReg   <= accNext;
    end
  end

  always_comb begin
    aligned      = running && (accReg == '0);
    strb.launch  = aligned && !restart;
    strb.restart = restart;
  end
endmodule

// File: rtl/ra_datapath.sv
module ra_datapath
  import ra_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  raStrobe_t         strb,
  input  logic [DATA_W-1:0] f2sData,
  input  logic              f2sValid,
  input  logic [DATA_W-1:0] s2fData,
  input  logic              s2fValid,
  output logic [DATA_W-1:0] toSlowData,
  output logic              toSlowValid,
  output logic [DATA_W-1:0] toFastData,
  output logic              toFastValid
);
  // Fast -> slow: held for a whole slow period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toSlowData  <= '0;
      toSlowValid <= 1'b0;
    end else if (strb.restart) begin
      toSlowValid <= 1'b0;
    end else if (strb.launch) begin
      toSlowData  <= f2sData;
      toSlowValid <= f2sValid;
    end
  end

  // Slow -> fast: data held, valid is a single fast-cycle pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toFastData  <= '0;
      toFastValid <= 1'b0;
    end else begin
      toFastValid <= strb.launch && s2fValid;
      if (strb.launch) toFastData <= s2fData;
    end
  end
endmodule

// File: rtl/ratio_aligner.sv
module ratio_aligner
  import ra_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RATIO_W = 5,
  parameter int MIN_Q   = 8,
  parameter int MAX_Q   = 21,
  parameter int LEAD    = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioCode,
  input  logic               restart,
  input  logic [DATA_W-1:0]  f2sData,
  input  logic               f2sValid,
  input  logic [DATA_W-1:0]  s2fData,
  input  logic               s2fValid,
  output logic               aligned,
  output logic [DATA_W-1:0]  toSlowData,
  output logic               toSlowValid,
  output logic [DATA_W-1:0]  toFastData,
  output logic               toFastValid
);
  localparam int QUARTERS = 4;

  raStrobe_t strb;

  ra_ctrl #(
    .RATIO_W(RATIO_W), .MIN_Q(MIN_Q), .MAX_Q(MAX_Q),
    .STEP(QUARTERS), .LEAD(LEAD)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ratioCode(ratioCode), .restart(restart),
    .strb(strb), .aligned(aligned)
  );

  ra_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .f2sData(f2sData), .f2sValid(f2sValid),
    .s2fData(s2fData), .s2fValid(s2fValid),
    .toSlowData(toSlowData), .toSlowValid(toSlowValid),
    .toFastData(toFastData), .toFastValid(toFastValid)
  );
endmodule

// File: rtl/ra_checker.sv
module ra_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              restart,
  input logic [DATA_W-1:0] f2sData,
  input logic              f2sValid,
  input logic [DATA_W-1:0] s2fData,
  input logic              s2fValid,
  input logic              aligned,
  input logic [DATA_W-1:0] toSlowData,
  input logic              toSlowValid,
  input logic [DATA_W-1:0] toFastData,
  input logic              toFastValid
);
  // R9
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    aligned |=> !aligned);

  // R6
  slow_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aligned && !restart) |=> (toSlowData == $past(f2sData)) && (toSlowValid == $past(f2sValid)));

  // R6
  slow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!aligned && !restart) |=> $stable(toSlowData) && $stable(toSlowValid));

  // R7
  fast_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aligned && !restart) |=> (toFastData == $past(s2fData)) && (toFastValid == $past(s2fValid)));

  // R7
  fast_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    toFastValid |-> ($past(aligned) && !$past(restart) && $past(s2fValid)));

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (!toSlowValid && !toFastValid));
endmodule

bind ratio_aligner ra_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .restart(restart),
  .f2sData(f2sData), .f2sValid(f2sValid),
  .s2fData(s2fData), .s2fValid(s2fValid),
  .aligned(aligned),
  .toSlowData(toSlowData), .toSlowValid(toSlowValid),
  .toFastData(toFastData), .toFastValid(toFastValid)
);

// File: tb/sim_ratio_aligner.sv
`timescale 1ns/1ps
module sim_ratio_aligner;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [4:0]    ratioCode = 5'd8;
  logic          restart = 1'b0;
  logic [DW-1:0] f2sData = '0;
  logic          f2sValid = 1'b0;
  logic [DW-1:0] s2fData = '0;
  logic          s2fValid = 1'b0;
  logic          aligned;
  logic [DW-1:0] toSlowData, toFastData;
  logic          toSlowValid, toFastValid;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  ratio_aligner #(.DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .ratioCode(ratioCode), .restart(restart),
    .f2sData(f2sData), .f2sValid(f2sValid), .s2fData(s2fData), .s2fValid(s2fValid),
    .aligned(aligned), .toSlowData(toSlowData), .toSlowValid(toSlowValid),
    .toFastData(toFastData), .toFastValid(toFastValid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // Model of R2: aligned in cycle k iff 4*(k+1) mod Q == 0
  function automatic bit expAligned(input int q, input int k);
    return ((4 * (k + 1)) % q) == 0;
  endfunction

  // Restart edge then land at the negedge of cycle 0
  task automatic restartWith(input int code);
    @(negedge clk);
    ratioCode = 5'(code);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic checkPattern(input int q, input int kStart, input int n, input string req);
    for (int k = kStart; k < kStart + n; k++) begin
      check(aligned == expAligned(q, k), req, aligned, expAligned(q, k));
      @(negedge clk);
    end
  endtask

  // R5
  task automatic tReset();
    @(negedge clk);
    check(aligned == 1'b0, "R5 aligned in reset", aligned, 0);
    check(toSlowValid == 1'b0 && toFastValid == 1'b0, "R5 valids in reset", {toSlowValid, toFastValid}, 0);
    check(toSlowData == '0 && toFastData == '0, "R5 data in reset", toSlowData, 0);
    rstN = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check(aligned == 1'b0, "R5 no aligned before restart", aligned, 0);
    end
  endtask

  // R1 R2 R9: several ratios, integer and fractional
  task automatic tPatterns();
    int qs[7] = '{8, 9, 10, 11, 13, 20, 21};
    foreach (qs[i]) begin
      restartWith(qs[i]);
      checkPattern(qs[i], 0, 2 * qs[i] + 3, $sformatf("R2 ratio %0d", qs[i]));
    end
  endtask

  // R3
  task automatic tClamp();
    restartWith(3);
    checkPattern(8, 0, 20, "R3 low code clamps to 8");
    restartWith(30);
    checkPattern(21, 0, 45, "R3 high code clamps to 21");
  endtask

  // R4: change without restart is ignored
  task automatic tIgnore();
    restartWith(10);
    checkPattern(10, 0, 7, "R4 before change");
    ratioCode = 5'd13;
    checkPattern(10, 7, 30, "R4 ignored ratio change");
  endtask

  // R6 R7: both directions launched on aligned cycles
  task automatic tData();
    logic [DW-1:0] expSD = toSlowData;
    logic          expSV;
    logic [DW-1:0] expFD = toFastData;
    logic          expFV = 1'b0;
    bit a;
    restartWith(10);
    expSV = 1'b0;
    for (int i = 0; i < 60; i++) begin
      check(aligned == expAligned(10, i), "R2 during data", aligned, expAligned(10, i));
      check(toSlowData == expSD, "R6 toSlowData", toSlowData, expSD);
      check(toSlowValid == expSV, "R6 toSlowValid", toSlowValid, expSV);
      check(toFastData == expFD, "R7 toFastData", toFastData, expFD);
      check(toFastValid == expFV, "R7 toFastValid pulse", toFastValid, expFV);
      a = aligned;
      f2sData  = DW'(16'h1000 + i);
      f2sValid = (i % 3) != 0;
      s2fData  = DW'(16'h8000 + 3 * i);
      s2fValid = (i % 2) == 0;
      if (a) begin
        expSD = f2sData;
        expSV = f2sValid;
        expFD = s2fData;
      end
      expFV = a && s2fValid;
      @(negedge clk);
    end
    f2sValid = 1'b1;
    s2fValid = 1'b1;
  endtask

  // R8: restart mid-run re-phases and clears valids
  task automatic tRestartMid();
    restartWith(9);
    checkPattern(9, 0, 4, "R8 first run");
    restartWith(9);
    check(toSlowValid == 1'b0, "R8 toSlowValid cleared", toSlowValid, 0);
    check(toFastValid == 1'b0, "R8 toFastValid cleared", toFastValid, 0);
    f2sValid = 1'b0;
    s2fValid = 1'b0;
    checkPattern(9, 0, 20, "R8 re-phased pattern");
  endtask

  initial begin
    tReset();
    tPatterns();
    tClamp();
    tIgnore();
    tData();
    tRestartMid();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule